// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the read and write strobes of an SRAM port and looks for one fixed run of six reads at chosen addresses. That run is a command hidden in ordinary traffic. Five fixed lead-in addresses must come first, in order. The sixth address selects the command: 0x8FC0 requests a store and 0x4C63 requests a recall. When the run completes, the block gives a one-clock pulse to a store/recall controller. The reads still reach the SRAM in the normal way. The block only observes them and never alters the data path.

A write at any point breaks a run that has started. So does a read at an address other than the one expected next. In both cases the block gives a one-clock abort pulse and issues no command. While the controller reports busy, all traffic is ignored. After a command is issued, traffic is also ignored until the controller has raised busy and then dropped it again. A chip-enable-timed read and an output-enable-timed read look the same at this boundary: each arrives as one `rd_vld` pulse. The output-enable level therefore plays no part.

The state machine has these states:
- `S_IDLE`: no match in progress.
- `S_M1` to `S_M5`: one to five lead-in reads matched.
- `S_CMD_ST` and `S_CMD_RC`: the command pulse is out.
- `S_WAIT_BUSY`: a command was issued and the block waits for busy to rise.
- `S_LOCK`: the controller is busy.

The transitions are:
- *start*: `S_IDLE` to `S_M1` on a read of the first key.
- *advance*: `S_Mk` to `S_Mk+1` on a read of the next key.
- *fire-store* and *fire-recall*: `S_M5` to `S_CMD_ST` or `S_CMD_RC`.
- *abort-idle*: `S_Mk` to `S_IDLE` on a write or a wrong read.
- *abort-restart*: `S_Mk` to `S_M1` on a wrong read that is the first key.
- *hold*: `S_CMD_*` to `S_WAIT_BUSY`.
- *lock*: any state except `S_LOCK` goes to `S_LOCK` when busy is high.
- *release*: `S_LOCK` to `S_IDLE` when busy is low.

Top module: `seq_cmd_detect`

## Requirements
- R1: After reset, `store_cmd`, `recall_cmd` and `seq_abort` are low and the matcher is idle.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, followed by a read at 0x8FC0, raise `store_cmd` for exactly one clock. The pulse appears in the cycle after the clock edge that samples the sixth read.
- R3: The same five lead-in reads, followed by a read at 0x4C63, raise `recall_cmd` for exactly one clock with the same timing as R2.
- R4: Only `rd_addr[15:0]` is compared with the keys. The upper address bits have no effect on matching.
- R5: A write while one to five keys are matched gives a one-clock `seq_abort` in the next cycle and returns the matcher to idle. A write while idle gives no pulse. A cycle where `rd_vld` and `wr_vld` are both high counts as a write.
- R6: A read at an address other than the next expected key, while one to five keys are matched, gives `seq_abort` in the next cycle and no command.
- R7: If the read that causes an abort is at 0x4E38, the matcher restarts with that read counted as step one.
- R8: While `busy` is high, accesses are ignored and no output pulses. A partial match is dropped without an abort, and the matcher is idle once `busy` falls.
- R9: After a command, accesses are ignored until `busy` has been seen high and then low.
- R10: Idle cycles between reads of a sequence do not break it. Only a read of the first key starts a match from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | One-cycle pulse for each completed read access |
| rd_addr | input | ADDR_W | Address of the read in the same cycle |
| wr_vld | input | 1 | One-cycle pulse for each completed write access (address irrelevant) |
| busy | input | 1 | Store/recall controller is executing |
| store_cmd | output | 1 | One-clock store request |
| recall_cmd | output | 1 | One-clock recall request |
| seq_abort | output | 1 | One-clock pulse when a started sequence is broken |

## Verification
The bench times every pulse to the exact cycle, so a design with an extra register stage, or one that holds a command high, fails on cycle or count. It breaks sequences with a write, with a stray read, with a wrong sixth address, and with a simultaneous read and write. A design that ignores any of these would issue a command the scoreboard never expected. A stray read of the first key must restart the match: an abort must be followed by a store five reads later, which a design that only goes idle would never issue. Sequences are also replayed during busy and in the window after a command, and with the upper address bits set. A design that leaks through the lock would fire, and a design that compares the full address would not fire when it should.

// File: rtl/seq_cmd_pkg.sv
package seq_cmd_pkg;

    localparam int CMP_W  = 16;
    localparam int N_KEYS = 7;
    localparam int KEY_ST = 5;
    localparam int KEY_RC = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_M1,
        S_M2,
        S_M3,
        S_M4,
        S_M5,
        S_CMD_ST,
        S_CMD_RC,
        S_WAIT_BUSY,
        S_LOCK
    } seq_state_e;

    // Key table: indices 0..4 are the lead-in, 5 selects store, 6 recall.
    function automatic logic [CMP_W-1:0] key_addr(input int idx);
        logic [CMP_W-1:0] k;
        case (idx)
            0:       k = 16'h4E38;
            1:       k = 16'hB1C7;
            2:       k = 16'h83E0;
            3:       k = 16'h7C1F;
            4:       k = 16'h703F;
            5:       k = 16'h8FC0;
            default: k = 16'h4C63;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/seq_key_match.sv
module seq_key_match
    import seq_cmd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_KEYS-1:0] hit
);

    for (genvar g = 0; g < N_KEYS; g++) begin : g_key
        assign hit[g] = (addr[CMP_W-1:0] == key_addr(g));
    end

    if (ADDR_W > CMP_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:CMP_W];
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic              wr_vld,
    input  logic              busy,
    input  logic [N_KEYS-1:0] hit,
    output logic              store_cmd,
    output logic              recall_cmd,
    output logic              seq_abort
);

    seq_state_e state, nxt;
    logic       abort_q, abort_nxt;
    logic       rd_only;
    logic       in_seq;

    function automatic int step_of(input seq_state_e s);
        int k;
        case (s)
            S_M1:    k = 1;
            S_M2:    k = 2;
            S_M3:    k = 3;
            S_M4:    k = 4;
            default: k = 0;
        endcase
        return k;
    endfunction

    function automatic seq_state_e after(input seq_state_e s);
        seq_state_e n;
        case (s)
            S_M1:    n = S_M2;
            S_M2:    n = S_M3;
            S_M3:    n = S_M4;
            default: n = S_M5;
        endcase
        return n;
    endfunction

    assign rd_only = rd_vld && !wr_vld;
    assign in_seq  = (state == S_M1) || (state == S_M2) || (state == S_M3)
                  || (state == S_M4) || (state == S_M5);

    always_comb begin
        nxt       = state;
        abort_nxt = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (busy)
                    nxt = S_LOCK;
                else if (rd_only && hit[0])
                    nxt = S_M1;
            end
            S_M1, S_M2, S_M3, S_M4: begin
                if (busy) begin
                    nxt = S_LOCK;
                end else if (wr_vld) begin
                    nxt       = S_IDLE;
                    abort_nxt = 1'b1;
                end else if (rd_vld) begin
                    if (hit[step_of(state)]) begin
                        nxt = after(state);
                    end else begin
                        nxt       = hit[0] ? S_M1 : S_IDLE;
                        abort_nxt = 1'b1;
                    end
                end
            end
            S_M5: begin
                if (busy) begin
                    nxt = S_LOCK;
                end else if (wr_vld) begin
                    nxt       = S_IDLE;
                    abort_nxt = 1'b1;
                end else if (rd_vld) begin
                    if (hit[KEY_ST])
                        nxt = S_CMD_ST;
                    else if (hit[KEY_RC])
                        nxt = S_CMD_RC;
                    else begin
                        nxt       = hit[0] ? S_M1 : S_IDLE;
                        abort_nxt = 1'b1;
                    end
                end
            end
            S_CMD_ST, S_CMD_RC, S_WAIT_BUSY:
                nxt = busy ? S_LOCK : S_WAIT_BUSY;
            S_LOCK:
                nxt = busy ? S_LOCK : S_IDLE;
            default:
                nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            abort_q <= 1'b0;
        end else begin
            state   <= nxt;
            abort_q <= abort_nxt;
        end
    end

    always_comb begin
        store_cmd  = (state == S_CMD_ST);
        recall_cmd = (state == S_CMD_RC);
        seq_abort  = abort_q;
    end

    a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_cmd, recall_cmd, seq_abort}));

    a_r2_store_after_fifth: assert property (@(posedge clk) disable iff (!rst_n)
        store_cmd |-> ($past(state) == S_M5) && $past(rd_vld));

    a_r2_store_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        store_cmd |=> !store_cmd);

    a_r3_recall_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        recall_cmd |=> !recall_cmd);

    a_r5_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_vld && in_seq) |=> seq_abort);

    a_r8_busy_silences: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(store_cmd || recall_cmd || seq_abort));

    a_r9_hold_until_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_BUSY) |=> (state == S_WAIT_BUSY) || (state == S_LOCK));

endmodule

// File: rtl/seq_cmd_detect.sv
module seq_cmd_detect
    import seq_cmd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_vld,
    input  logic              busy,
    output logic              store_cmd,
    output logic              recall_cmd,
    output logic              seq_abort
);

    logic [N_KEYS-1:0] hit;

    seq_key_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (rd_addr),
        .hit  (hit)
    );

    seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_vld     (rd_vld),
        .wr_vld     (wr_vld),
        .busy       (busy),
        .hit        (hit),
        .store_cmd  (store_cmd),
        .recall_cmd (recall_cmd),
        .seq_abort  (seq_abort)
    );

endmodule

// File: tb/test_seq_cmd_detect.sv
module test_seq_cmd_detect;

    localparam int AW = 24;
    localparam logic [2:0] E_ST = 3'b100;
    localparam logic [2:0] E_RC = 3'b010;
    localparam logic [2:0] E_AB = 3'b001;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_vld;
    logic [AW-1:0] rd_addr;
    logic          wr_vld;
    logic          busy;
    logic          store_cmd, recall_cmd, seq_abort;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int       at;
        logic [2:0] code;
        string    req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_cmd_detect #(.ADDR_W(AW)) i_seq_cmd_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_vld     (rd_vld),
        .rd_addr    (rd_addr),
        .wr_vld     (wr_vld),
        .busy       (busy),
        .store_cmd  (store_cmd),
        .recall_cmd (recall_cmd),
        .seq_abort  (seq_abort)
    );

    // Driver tasks: called at a falling edge, hold the strobe one cycle.
    task automatic expect_ev(input logic [2:0] code, input string req);
        exp_t e;
        if (code != 3'b000) begin
            e.at = cyc + 1; e.code = code; e.req = req;
            sb.push_back(e);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [2:0] code, input string req,
                      input logic [AW-17:0] hi = '0);
        rd_vld  = 1'b1;
        rd_addr = {hi, a};
        expect_ev(code, req);
        @(negedge clk);
        rd_vld  = 1'b0;
    endtask

    task automatic wr(input logic [2:0] code, input string req, input logic with_rd = 1'b0);
        wr_vld  = 1'b1;
        rd_vld  = with_rd;
        rd_addr = 24'h00B1C7;
        expect_ev(code, req);
        @(negedge clk);
        wr_vld  = 1'b0;
        rd_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic lead(input int n, input logic [AW-17:0] hi = '0);
        logic [15:0] keys [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
        for (int i = 0; i < n; i++) rd(keys[i], 3'b000, "", hi);
    endtask

    task automatic busy_pulse(input int n);
        busy = 1'b1;
        idle(n);
        busy = 1'b0;
        idle(1);
    endtask

    // Monitor: pop and compare every pulse against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            logic [2:0] got;
            got = {store_cmd, recall_cmd, seq_abort};
            while (sb.size() > 0 && sb[0].at < cyc) begin
                total++; bad++;
                $display("FAIL %s: missed pulse, actual=000 expected=%b at cycle %0d",
                         sb[0].req, sb[0].code, sb[0].at);
                void'(sb.pop_front());
            end
            if (got != 3'b000) begin
                total++;
                if (sb.size() == 0) begin
                    bad++;
                    $display("FAIL R8/R9: unexpected pulse actual=%b expected=000 cycle %0d", got, cyc);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (got != e.code || e.at != cyc) begin
                        bad++;
                        $display("FAIL %s: actual=%b@%0d expected=%b@%0d", e.req, got, cyc, e.code, e.at);
                    end
                end
            end
        end
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_vld = 1'b0; wr_vld = 1'b0; busy = 1'b0; rd_addr = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        total++;
        if ({store_cmd, recall_cmd, seq_abort} !== 3'b000) begin
            bad++;
            $display("FAIL R1: actual=%b expected=000", {store_cmd, recall_cmd, seq_abort});
        end

        // R2: store
        lead(5); rd(16'h8FC0, E_ST, "R2");
        busy_pulse(3);
        // R3: recall
        lead(5); rd(16'h4C63, E_RC, "R3");
        busy_pulse(2);
        // R4: upper bits ignored
        lead(5, 8'hA5); rd(16'h8FC0, E_ST, "R4", 8'h5A);
        busy_pulse(2);
        // R5: write in idle ignored, write mid-run aborts
        wr(3'b000, "R5");
        lead(2); wr(E_AB, "R5");
        rd(16'h83E0, 3'b000, "R5"); rd(16'h7C1F, 3'b000, "R5");
        rd(16'h703F, 3'b000, "R5"); rd(16'h8FC0, 3'b000, "R5");
        // R5: simultaneous read and write counts as a write
        lead(1); wr(E_AB, "R5", 1'b1);
        rd(16'h83E0, 3'b000, "R5");
        // R6: stray read mid-run and wrong sixth address
        lead(3); rd(16'h1234, E_AB, "R6"); rd(16'h703F, 3'b000, "R6");
        lead(5); rd(16'hFFFF, E_AB, "R6");
        // R7: stray read of the first key restarts at step one
        lead(3); rd(16'h4E38, E_AB, "R7");
        rd(16'hB1C7, 3'b000, "R7"); rd(16'h83E0, 3'b000, "R7");
        rd(16'h7C1F, 3'b000, "R7"); rd(16'h703F, 3'b000, "R7");
        rd(16'h8FC0, E_ST, "R7");
        busy_pulse(2);
        // R8: busy drops a partial run silently, accesses ignored
        lead(3);
        busy = 1'b1;
        rd(16'h7C1F, 3'b000, "R8"); wr(3'b000, "R8");
        lead(5); rd(16'h4C63, 3'b000, "R8");
        busy = 1'b0;
        idle(1);
        rd(16'h7C1F, 3'b000, "R8"); rd(16'h703F, 3'b000, "R8"); rd(16'h8FC0, 3'b000, "R8");
        // R9: accesses after a command ignored until busy rises and falls
        lead(5); rd(16'h8FC0, E_ST, "R9");
        lead(5); rd(16'h4C63, 3'b000, "R9"); wr(3'b000, "R9");
        busy_pulse(2);
        lead(5); rd(16'h4C63, E_RC, "R9");
        busy_pulse(1);
        // R10: gaps between reads keep the run; non-first key in idle is inert
        rd(16'hB1C7, 3'b000, "R10");
        rd(16'h4E38, 3'b000, "R10"); idle(3);
        rd(16'hB1C7, 3'b000, "R10"); idle(2);
        rd(16'h83E0, 3'b000, "R10"); idle(4);
        rd(16'h7C1F, 3'b000, "R10"); idle(1);
        rd(16'h703F, 3'b000, "R10"); idle(5);
        rd(16'h8FC0, E_ST, "R10");
        busy_pulse(2);

        idle(5);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2: pending=%0d expected=0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule